// File: doc/BRIEF.md
# Serial Configuration Loader

This block writes a configuration image into a slave programmable device through that device's bit-serial configuration port. After a start pulse it pulls the program line low and waits for the device's active-low INIT line to fall. It keeps program low a little longer, then releases it and waits for INIT to return high. It then takes image bytes one at a time from a valid/ready stream. Each byte goes out on a data line, most significant bit first, against a configuration clock whose half-period is set at run time.

Before each new byte the loader checks the device's INIT and DONE lines. If INIT is low while DONE is still low, the device has signalled a checksum failure, and the load stops. After the last byte the data line is held high and the clock keeps running until DONE rises. Each waiting stage has its own timeout. The outcome stays visible until the next start: a success flag, or a failure flag together with one cause flag.

Top module: `serial_cfg_loader`

## Requirements
- R1: A start pulse accepted while not busy drives `prog_n_o` low. If `init_n_i` is not seen low within TIMEOUT_CYC cycles, the loader fails with `err_init_fall_o`. `fail_o` rises exactly TIMEOUT_CYC clock edges after the edge that samples `start`.
- R2: Once `init_n_i` is seen low, `prog_n_o` stays low for PROG_HOLD_CYC more cycles and is then released. The loader then waits for `init_n_i` high, with the same timeout. Expiry gives a failure with `err_init_rise_o`.
- R3: Every byte goes out as 8 bits, most significant bit first. For each bit, `cclk_o` falls on the same edge that puts the bit on `din_o`, then rises. The device samples on the rising edge.
- R4: Before each byte is taken, `init_n_i` low while `done_i` is low ends the load with `err_crc_o`. No further byte is taken.
- R5: Each low phase of `cclk_o` lasts `half_period` cycles, and a value of 0 counts as 1. `din_o` never changes during a low phase or on a rising edge.
- R6: `s_ready` is high only between bytes. A byte is accepted only after all 8 bits of the previous byte have been clocked out. Exactly `byte_count` bytes are accepted, and gaps in `s_valid` are tolerated.
- R7: After the last byte, or at once when `byte_count` is 0, `din_o` is held at 1 and `cclk_o` keeps toggling at the half-period. When `done_i` is seen high, `ok_o` rises.
- R8: If `done_i` does not rise within TIMEOUT_CYC cycles of the end of data, the loader fails with `err_done_o`. Every failure carries exactly one cause flag.
- R9: A start pulse during a load is ignored. The load in progress, its byte count and its result are unaffected.
- R10: After reset: `prog_n_o`=1, `cclk_o`=1, `din_o`=1, `s_ready`=0, `busy_o`=0, `ok_o`=0, `fail_o`=0, and all cause flags are 0.
- R11: `ok_o` or `fail_o` and the cause flags hold until the next accepted start. That start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a load |
| byte_count | input | CNT_W | Number of image bytes, sampled at start |
| half_period | input | HP_W | Configuration clock half-period in system cycles (0 acts as 1) |
| s_valid | input | 1 | Image byte valid |
| s_data | input | 8 | Image byte |
| s_ready | output | 1 | Loader takes the byte this cycle |
| init_n_i | input | 1 | Device INIT line, active low |
| done_i | input | 1 | Device DONE line, active high |
| prog_n_o | output | 1 | Device program line, active low |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load finished with DONE high |
| fail_o | output | 1 | Last load failed |
| err_crc_o | output | 1 | Failure cause: device checksum error |
| err_init_fall_o | output | 1 | Failure cause: INIT never fell |
| err_init_rise_o | output | 1 | Failure cause: INIT never rose |
| err_done_o | output | 1 | Failure cause: DONE never rose |

## Verification
The INIT-fall timeout is the one result the bench times absolutely. `fail_o` must still be low TIMEOUT_CYC-1 edges after the start edge and high one edge later, and both samples are taken 2 time units after a rising edge.

Bit-level timing is measured by a device model that samples on every falling system edge. It records each configuration-clock low phase in whole cycles, checks it against the half-period, and collects `din_o` on each rising configuration edge. Because of that sampling point, a one-cycle shift in any register on the path shows up as a wrong phase length or a wrong bit.

The model raises DONE a set number of flush edges after the data. The bench then checks that exactly that many flush edges occurred. This holds because the state register reacts to DONE on the next edge, before any further rising configuration edge can occur.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_LOW,
        ST_PROG_HOLD,
        ST_INIT_RISE,
        ST_FETCH,
        ST_SHIFT,
        ST_FLUSH,
        ST_OK,
        ST_FAIL
    } ld_state_e;

    typedef struct packed {
        logic crc;
        logic init_fall;
        logic init_rise;
        logic done_to;
    } ld_err_t;

    // states in which the stage timeout counter runs
    function automatic logic is_timed(ld_state_e s);
        return (s == ST_PROG_LOW) || (s == ST_INIT_RISE) || (s == ST_FLUSH);
    endfunction

    // states in which a new start is accepted
    function automatic logic is_rest(ld_state_e s);
        return (s == ST_IDLE) || (s == ST_OK) || (s == ST_FAIL);
    endfunction

endpackage

// File: rtl/cfgl_tick_gen.sv
module cfgl_tick_gen #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [HP_W-1:0] half_period,
    output logic            tick
);
    logic [HP_W-1:0] cnt;
    logic [HP_W-1:0] last;

    assign last = (half_period == '0) ? '0 : half_period - HP_W'(1);
    assign tick = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + HP_W'(1);
    end

    p_tick_window_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= last));
endmodule

// File: rtl/cfgl_cycle_timer.sv
module cfgl_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expired = en && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) cnt <= '0;
        else            cnt <= cnt + W'(1);
    end

    p_timer_bound_r1: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < W'(LIMIT)));
endmodule

// File: rtl/cfgl_bit_shifter.sv
module cfgl_bit_shifter
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prime,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              tick,
    input  logic              run_shift,
    input  logic              run_flush,
    output logic              cclk,
    output logic              din,
    output logic              byte_end
);
    localparam int CW = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] shreg;
    logic [CW-1:0]     nsent;

    assign byte_end = run_shift && tick && cclk && (nsent == CW'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            nsent <= '0;
            cclk  <= 1'b1;
            din   <= 1'b1;
        end else if (prime) begin
            // park the clock high; data is left alone so no edge sees it move
            cclk  <= 1'b1;
            nsent <= '0;
        end else if (load) begin
            shreg <= load_byte;
            din   <= load_byte[BYTE_W-1];
            cclk  <= 1'b0;
            nsent <= '0;
        end else if (run_shift && tick) begin
            if (!cclk) begin
                cclk  <= 1'b1;
                nsent <= nsent + CW'(1);
            end else if (nsent != CW'(BYTE_W)) begin
                cclk  <= 1'b0;
                din   <= shreg[BYTE_W-2];
                shreg <= shreg << 1;
            end
        end else if (run_flush) begin
            din <= 1'b1;
            if (tick) cclk <= ~cclk;
        end
    end

    p_din_setup_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk) |-> $stable(din));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfgl_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int HP_W          = 8,
    parameter int TIMEOUT_CYC   = 500000,
    parameter int PROG_HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [HP_W-1:0]   half_period,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    output logic              s_ready,
    input  logic              init_n_i,
    input  logic              done_i,
    output logic              prog_n_o,
    output logic              cclk_o,
    output logic              din_o,
    output logic              busy_o,
    output logic              ok_o,
    output logic              fail_o,
    output logic              err_crc_o,
    output logic              err_init_fall_o,
    output logic              err_init_rise_o,
    output logic              err_done_o
);
    ld_state_e        state, nxt;
    ld_err_t          err_q, err_nxt;
    logic [CNT_W-1:0] remaining;

    logic start_ok, crc_cond, accept;
    logic wait_exp, hold_exp, tick, byte_end;

    assign start_ok = start && is_rest(state);
    assign crc_cond = !init_n_i && !done_i;
    assign s_ready  = (state == ST_FETCH) && (remaining != '0) && !crc_cond;
    assign accept   = s_ready && s_valid;

    cfgl_cycle_timer #(.LIMIT(TIMEOUT_CYC)) u_stage_timer (
        .clk(clk), .rst(rst), .en(is_timed(state)), .expired(wait_exp)
    );

    cfgl_cycle_timer #(.LIMIT(PROG_HOLD_CYC)) u_hold_timer (
        .clk(clk), .rst(rst), .en(state == ST_PROG_HOLD), .expired(hold_exp)
    );

    cfgl_tick_gen #(.HP_W(HP_W)) u_tick (
        .clk(clk), .rst(rst),
        .run((state == ST_SHIFT) || (state == ST_FLUSH)),
        .half_period(half_period), .tick(tick)
    );

    cfgl_bit_shifter u_shift (
        .clk(clk), .rst(rst),
        .prime(start_ok), .load(accept), .load_byte(s_data),
        .tick(tick),
        .run_shift(state == ST_SHIFT), .run_flush(state == ST_FLUSH),
        .cclk(cclk_o), .din(din_o), .byte_end(byte_end)
    );

    always_comb begin
        nxt     = state;
        err_nxt = err_q;
        unique case (state)
            ST_IDLE, ST_OK, ST_FAIL: begin
                if (start) begin
                    nxt     = ST_PROG_LOW;
                    err_nxt = '0;
                end
            end
            ST_PROG_LOW: begin
                if (!init_n_i) nxt = ST_PROG_HOLD;
                else if (wait_exp) begin
                    nxt = ST_FAIL;
                    err_nxt.init_fall = 1'b1;
                end
            end
            ST_PROG_HOLD: begin
                if (hold_exp) nxt = ST_INIT_RISE;
            end
            ST_INIT_RISE: begin
                if (init_n_i) nxt = ST_FETCH;
                else if (wait_exp) begin
                    nxt = ST_FAIL;
                    err_nxt.init_rise = 1'b1;
                end
            end
            ST_FETCH: begin
                if (remaining == '0) nxt = ST_FLUSH;
                else if (crc_cond) begin
                    nxt = ST_FAIL;
                    err_nxt.crc = 1'b1;
                end else if (s_valid) nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (byte_end) nxt = ST_FETCH;
            end
            ST_FLUSH: begin
                if (done_i) nxt = ST_OK;
                else if (wait_exp) begin
                    nxt = ST_FAIL;
                    err_nxt.done_to = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            err_q     <= '0;
            remaining <= '0;
        end else begin
            state <= nxt;
            err_q <= err_nxt;
            if (start_ok)    remaining <= byte_count;
            else if (accept) remaining <= remaining - CNT_W'(1);
        end
    end

    assign prog_n_o        = !((state == ST_PROG_LOW) || (state == ST_PROG_HOLD));
    assign busy_o          = !is_rest(state);
    assign ok_o            = (state == ST_OK);
    assign fail_o          = (state == ST_FAIL);
    assign err_crc_o       = err_q.crc;
    assign err_init_fall_o = err_q.init_fall;
    assign err_init_rise_o = err_q.init_rise;
    assign err_done_o      = err_q.done_to;

    p_prog_after_start_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_n_o) |-> $past(start));

    p_crc_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(err_crc_o) |-> $past(!init_n_i && !done_i));

    p_take_once_r6: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_ready) |=> !s_ready);

    p_flush_high_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_FLUSH) && $rose(cclk_o)) |-> din_o);

    p_ok_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_o) |-> $past(done_i));

    p_fail_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> ($countones(err_q) == 1));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start) |=> $stable(prog_n_o) || (state != ST_PROG_LOW));
endmodule

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
    localparam int CLK_P = 10;
    localparam int T_OUT = 60;
    localparam int HOLD  = 3;
    localparam int CW    = 8;
    localparam int HW    = 8;

    // {count, half period, first byte, step, done-after, stall}
    localparam logic [47:0] VEC [5] = '{
        48'h03_01_A5_3C_02_00,
        48'h05_02_80_01_01_00,
        48'h01_03_01_00_04_00,
        48'h04_00_FF_11_03_00,
        48'h06_04_5A_77_02_01
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic [HW-1:0] half_period = 8'd1;
    logic s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic init_n = 1'b1, done = 1'b0;
    logic s_ready, prog_n_o, cclk_o, din_o, busy_o, ok_o, fail_o;
    logic err_crc_o, err_init_fall_o, err_init_rise_o, err_done_o;

    serial_cfg_loader #(.CNT_W(CW), .HP_W(HW), .TIMEOUT_CYC(T_OUT), .PROG_HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count), .half_period(half_period),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .init_n_i(init_n), .done_i(done),
        .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
        .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o),
        .err_crc_o(err_crc_o), .err_init_fall_o(err_init_fall_o),
        .err_init_rise_o(err_init_rise_o), .err_done_o(err_done_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_checks = 0, n_err = 0;

    task automatic check_eq(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    int fall_dly, rise_dly, done_after, crc_at, exp_n;
    int phase, cnt, hold_cnt, nbits, flush_rises, flush_bad, din_bad;
    int low_cnt, low_min, low_max;
    bit init_risen;
    logic prev_cclk = 1'b1, prev_din = 1'b1;
    logic [7:0] cap [0:15];

    task automatic model_reset(int fdly, int rdly, int dafter, int crcat, int n);
        fall_dly = fdly; rise_dly = rdly; done_after = dafter; crc_at = crcat; exp_n = n;
        phase = 0; cnt = 0; hold_cnt = 0; nbits = 0; flush_rises = 0; flush_bad = 0;
        din_bad = 0; low_cnt = 0; low_min = 1000; low_max = 0; init_risen = 0;
        init_n = 1'b1; done = 1'b0;
    endtask

    always @(negedge clk) begin
        if (phase == 0) begin
            if (!prog_n_o) begin phase = 1; cnt = 0; end
        end else if (phase == 1) begin
            if (!prog_n_o) begin
                if (!init_n) hold_cnt++;
                cnt++;
                if (fall_dly >= 0 && cnt >= fall_dly) init_n = 1'b0;
            end else begin
                phase = 2; cnt = 0;
            end
        end else if (phase == 2) begin
            if (!init_risen) begin
                cnt++;
                if (rise_dly >= 0 && cnt >= rise_dly) begin init_n = 1'b1; init_risen = 1; end
            end else begin
                if (!cclk_o) low_cnt++;
                if (din_o !== prev_din && ((cclk_o && !prev_cclk) || (!cclk_o && !prev_cclk)))
                    din_bad++;
                if (cclk_o && !prev_cclk) begin
                    if (low_cnt < low_min) low_min = low_cnt;
                    if (low_cnt > low_max) low_max = low_cnt;
                    low_cnt = 0;
                    if (nbits < 8 * exp_n) begin
                        cap[nbits/8] = {cap[nbits/8][6:0], din_o};
                        nbits++;
                        if (crc_at >= 0 && nbits == 8 * crc_at) init_n = 1'b0;
                    end else begin
                        flush_rises++;
                        if (!din_o) flush_bad++;
                        if (done_after >= 0 && flush_rises >= done_after) done = 1'b1;
                    end
                end
            end
        end
        prev_cclk = cclk_o;
        prev_din  = din_o;
    end

    // ---------------- byte stream ----------------
    int s_first, s_step, s_idx, s_len, cyc;
    bit s_en = 0, s_stall = 0, taken = 0;

    function automatic logic [7:0] sbyte(input int i);
        return 8'(s_first + i * s_step);
    endfunction

    always begin
        @(negedge clk);
        #1;
        if (taken) begin s_idx++; taken = 0; end
        cyc++;
        s_valid = s_en && (s_idx < s_len) && !(s_stall && (cyc % 3 == 1));
        s_data  = sbyte(s_idx);
        taken   = s_valid && s_ready;
    end

    task automatic run_load(int n, int hp, int first, int step, int dafter, bit stall,
                            int fdly, int rdly, int crcat, bit poke);
        model_reset(fdly, rdly, dafter, crcat, n);
        s_first = first; s_step = step; s_idx = 0; s_len = n; s_stall = stall; taken = 0;
        s_en = 1;
        @(negedge clk);
        #2;
        start = 1'b1; byte_count = CW'(n); half_period = HW'(hp);
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk);
            #2;
            if (k == 0) start = 1'b0;
            if (poke && k == 25) begin start = 1'b1; byte_count = CW'(n + 3); end
            if (poke && k == 26) begin
                start = 1'b0; byte_count = CW'(n);
                check_eq("R9 busy kept after stray start", busy_o, 1);
            end
            if (ok_o || fail_o) break;
        end
        s_en = 0;
    endtask

    task automatic check_good(string tag, int n, int hp, int dafter);
        check_eq({tag, " R7 ok"}, ok_o, 1);
        check_eq({tag, " R8 no cause"}, {err_crc_o, err_init_fall_o, err_init_rise_o, err_done_o}, 0);
        check_eq({tag, " R3 bit count"}, nbits, 8 * n);
        for (int i = 0; i < n; i++) check_eq({tag, " R3 byte"}, cap[i], sbyte(i));
        check_eq({tag, " R6 bytes taken"}, s_idx, n);
        check_eq({tag, " R5 low min"}, low_min, (hp == 0) ? 1 : hp);
        check_eq({tag, " R5 low max"}, low_max, (hp == 0) ? 1 : hp);
        check_eq({tag, " R5 din stable"}, din_bad, 0);
        check_eq({tag, " R7 flush edges"}, flush_rises, dafter);
        check_eq({tag, " R7 flush data high"}, flush_bad, 0);
        check_eq({tag, " R2 prog hold"}, hold_cnt, HOLD);
    endtask

    bit finished = 0;

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset(-1, -1, -1, -1, 0);
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk);
        #2;
        // R10 reset state
        check_eq("R10 prog_n", prog_n_o, 1);
        check_eq("R10 cclk", cclk_o, 1);
        check_eq("R10 din", din_o, 1);
        check_eq("R10 s_ready", s_ready, 0);
        check_eq("R10 busy/ok/fail", {busy_o, ok_o, fail_o}, 0);
        check_eq("R10 causes", {err_crc_o, err_init_fall_o, err_init_rise_o, err_done_o}, 0);

        // R1 exact INIT-fall timeout
        model_reset(-1, -1, -1, -1, 0);
        @(negedge clk);
        #2 start = 1'b1; byte_count = 8'd2;
        @(posedge clk);
        #2 start = 1'b0;
        check_eq("R1 prog asserted", prog_n_o, 0);
        repeat (T_OUT - 1) @(posedge clk);
        #2 check_eq("R1 no fail before timeout", fail_o, 0);
        @(posedge clk);
        #2 check_eq("R1 fail at timeout", fail_o, 1);
        check_eq("R1 cause init_fall", {err_crc_o, err_init_fall_o, err_init_rise_o, err_done_o}, 4'b0100);
        check_eq("R1 prog released after fail", prog_n_o, 1);

        // vector table of good loads
        for (int v = 0; v < 5; v++) begin
            run_load(int'(VEC[v][47:40]), int'(VEC[v][39:32]), int'(VEC[v][31:24]),
                     int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][0], 4, 6, -1, 0);
            check_good($sformatf("vec%0d", v), int'(VEC[v][47:40]), int'(VEC[v][39:32]),
                       int'(VEC[v][15:8]));
        end

        // R11 result held
        repeat (10) @(posedge clk);
        #2 check_eq("R11 ok held", ok_o, 1);

        // R2 INIT never rises
        run_load(3, 1, 8'h11, 1, 2, 0, 3, -1, -1, 0);
        check_eq("R2 fail", fail_o, 1);
        check_eq("R2 cause init_rise", {err_crc_o, err_init_fall_o, err_init_rise_o, err_done_o}, 4'b0010);
        check_eq("R2 no byte taken", s_idx, 0);
        check_eq("R2 prog hold", hold_cnt, HOLD);

        // R4 checksum error after two bytes
        run_load(4, 2, 8'h3C, 8'h21, 2, 0, 2, 3, 2, 0);
        check_eq("R4 fail", fail_o, 1);
        check_eq("R4 cause crc", {err_crc_o, err_init_fall_o, err_init_rise_o, err_done_o}, 4'b1000);
        check_eq("R4 R6 bytes taken", s_idx, 2);
        check_eq("R4 s_ready low", s_ready, 0);

        // R11 new start clears causes
        run_load(2, 1, 8'hC3, 8'h0F, 1, 0, 2, 2, -1, 0);
        check_good("R11 clear", 2, 1, 1);

        // R8 DONE timeout
        run_load(2, 1, 8'h96, 8'h01, -1, 0, 2, 2, -1, 0);
        check_eq("R8 fail", fail_o, 1);
        check_eq("R8 cause done", {err_crc_o, err_init_fall_o, err_init_rise_o, err_done_o}, 4'b0001);
        check_eq("R8 R7 flush clocks ran", int'(flush_rises > 0), 1);
        check_eq("R8 R7 flush data high", flush_bad, 0);

        // R7 zero bytes
        run_load(0, 2, 0, 0, 3, 0, 2, 2, -1, 0);
        check_good("R7 zero", 0, 2, 3);

        // R9 stray start during load
        run_load(4, 2, 8'h6E, 8'h13, 2, 0, 2, 2, -1, 1);
        check_good("R9 stray start", 4, 2, 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule